// File: doc/BRIEF.md
# E3 Maintenance Byte Transmit Generator

This block assembles the 8-bit maintenance-and-adaptation overhead byte that an E3 framer inserts once per transmitted frame. On each frame-start strobe it takes a snapshot of its configuration inputs and builds a new byte. Those inputs are the payload-type field, the payload-dependent pair, the timing marker, a 4-bit synchronisation status message (SSM), an SSM-mode enable and an external-source select. The two far-end flags also enter the snapshot. The byte then holds for the whole frame, so a register change made in mid-frame takes effect only at the next frame start.

Bits 6 and 7 and bit 8 of the byte change meaning with SSM mode. When SSM mode is off, bits 6 and 7 carry payload-dependent bits and bit 8 carries the timing marker. When SSM mode is on, bits 6 and 7 carry a 2-bit multiframe indicator (MI). The MI comes either from a free-running internal counter or from a serial external overhead stream. The MI value then picks which SSM bit goes into bit 8, so the full message goes out over four frames.

A small capture state machine follows the serial external stream. Its states are IDLE (after reset, before the first strobe), SEEK (counting the leading bits), TAKE_HI (waiting for bit position 6), TAKE_LO (waiting for position 7) and DONE (ignoring the rest of the frame). Its transitions are:
- Any state goes to SEEK on a frame strobe, or straight to TAKE_HI if the leading count is already met.
- SEEK goes to TAKE_HI on the fifth counted bit.
- TAKE_HI goes to TAKE_LO when a bit arrives.
- TAKE_LO goes to DONE when a bit arrives.
- IDLE and DONE stay put until the next strobe.

Top module: `e3ma_tx_gen`

## Requirements
- R1: While reset is asserted, `ma_byte` is 8'h00 and `byte_new` is 0.
- R2: `ma_byte` changes only in the cycle after a cycle with `frame_start` high. `byte_new` is high in exactly that cycle.
- R3: Byte bit 1 (`ma_byte[7]`, sent first) carries `far_fail` and bit 2 (`ma_byte[6]`) carries `far_err`, both as sampled at the strobe.
- R4: Bits 3..5 (`ma_byte[5:3]`) carry `cfg_ptype`, with `cfg_ptype[2]` in bit 3. A change between strobes has no effect until the next strobe.
- R5: With `cfg_ssm_on`=0 and `cfg_ext_sel`=0, bits 6,7 (`ma_byte[2:1]`) carry `cfg_pdep`, with `cfg_pdep[1]` in bit 6.
- R6: With `cfg_ssm_on`=0 and `cfg_ext_sel`=1, bits 6,7 carry the held external pair: bit 6 is the last external bit captured at serial position 6, and bit 7 is the last captured at position 7.
- R7: Serial positions count bits with `ovh_valid` high from the strobe onward, and a valid bit in the strobe cycle is position 1. Each of positions 6 and 7 replaces its own held value when it arrives. Bits beyond position 7, and frames too short to reach a position, leave that held value unchanged.
- R8: With `cfg_ssm_on`=0, bit 8 (`ma_byte[0]`) carries `cfg_tmark`.
- R9: With `cfg_ssm_on`=1 and `cfg_ext_sel`=0, bits 6,7 carry an internal 2-bit MI that advances by one each frame and wraps from 11 to 00.
- R10: In the first frame after automatic MI generation becomes enabled (or after reset), the internal MI sent is 00.
- R11: With `cfg_ssm_on`=1, bit 8 carries `cfg_ssm[3-MI]`, where MI is the value sent in bits 6,7. MI 00 selects `cfg_ssm[3]` (SSM bit 1) and MI 11 selects `cfg_ssm[0]`.
- R12: With `cfg_ssm_on`=1 and `cfg_ext_sel`=1, the MI sent is the held external pair described in R6, and that pair also drives the selection in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| far_fail | input | 1 | Far-end receive failure flag |
| far_err | input | 1 | Far-end block error flag |
| cfg_ptype | input | 3 | Payload type field |
| cfg_pdep | input | 2 | Payload-dependent bits (SSM mode off) |
| cfg_tmark | input | 1 | Timing marker (SSM mode off) |
| cfg_ssm | input | 4 | SSM message; [3] is SSM bit 1 |
| cfg_ssm_on | input | 1 | SSM mode enable |
| cfg_ext_sel | input | 1 | 1 selects the external stream for bits 6,7 |
| ovh_valid | input | 1 | External overhead bit valid |
| ovh_bit | input | 1 | External overhead serial bit |
| ma_byte | output | 8 | Assembled byte; [7] is bit 1 |
| byte_new | output | 1 | High for one cycle when a new byte is loaded |

## Verification
The bench runs the internal MI counter across its wrap and leaves automatic mode and re-enters it. A counter that failed to clear would resume mid-sequence and put the wrong SSM bit in bit 8. It feeds external streams that are short, exact and overlong, with gaps in `ovh_valid`. A capture machine that counted raw cycles, or that kept sampling after position 7, would hold the wrong pair. It also scrambles every configuration input in mid-frame, which catches any path that leaks into the byte between strobes.

// File: rtl/e3ma_pkg.sv
package e3ma_pkg;

    // Width of the assembled overhead byte.
    localparam int MA_W = 8;

    // States of the external serial capture machine.
    typedef enum logic [2:0] {
        CAP_IDLE,
        CAP_SEEK,
        CAP_TAKE_HI,
        CAP_TAKE_LO,
        CAP_DONE
    } cap_state_e;

    // Source of bits 6 and 7.
    typedef enum logic [1:0] {
        SRC_PD_REG,
        SRC_PD_EXT,
        SRC_MI_AUTO,
        SRC_MI_EXT
    } pair_src_e;

    function automatic pair_src_e decode_src(input logic ssm_on, input logic ext_sel);
        pair_src_e s;
        unique case ({ssm_on, ext_sel})
            2'b00:   s = SRC_PD_REG;
            2'b01:   s = SRC_PD_EXT;
            2'b10:   s = SRC_MI_AUTO;
            default: s = SRC_MI_EXT;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/e3ma_ext_capture.sv
// Follows the serial external overhead stream and keeps the two bits found
// at positions FIRST_POS and FIRST_POS+1 (FIRST_POS must be 2..BYTE_BITS-1).
module e3ma_ext_capture
    import e3ma_pkg::*;
#(
    parameter int BYTE_BITS = 8,
    parameter int FIRST_POS = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       ovh_valid,
    input  logic       ovh_bit,
    output logic [1:0] ext_pair
);

    localparam int POS_W = $clog2(BYTE_BITS + 1);
    localparam logic [POS_W-1:0] SEEK_END = POS_W'(FIRST_POS - 1);
    localparam logic [POS_W-1:0] ONE      = POS_W'(1);

    cap_state_e       state, state_n;
    logic [POS_W-1:0] pos, pos_n;
    logic             take_hi, take_lo;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CAP_IDLE;
            pos   <= '0;
        end else begin
            state <= state_n;
            pos   <= pos_n;
        end
    end

    // Next state.
    always_comb begin
        state_n = state;
        pos_n   = pos;
        take_hi = 1'b0;
        take_lo = 1'b0;
        if (frame_start) begin
            if (ovh_valid) begin
                pos_n   = ONE;
                state_n = (ONE == SEEK_END) ? CAP_TAKE_HI : CAP_SEEK;
            end else begin
                pos_n   = '0;
                state_n = CAP_SEEK;
            end
        end else begin
            unique case (state)
                CAP_IDLE: begin
                    state_n = CAP_IDLE;
                end
                CAP_SEEK: begin
                    if (ovh_valid) begin
                        pos_n = pos + ONE;
                        if ((pos + ONE) == SEEK_END) begin
                            state_n = CAP_TAKE_HI;
                        end
                    end
                end
                CAP_TAKE_HI: begin
                    if (ovh_valid) begin
                        take_hi = 1'b1;
                        pos_n   = pos + ONE;
                        state_n = CAP_TAKE_LO;
                    end
                end
                CAP_TAKE_LO: begin
                    if (ovh_valid) begin
                        take_lo = 1'b1;
                        pos_n   = pos + ONE;
                        state_n = CAP_DONE;
                    end
                end
                CAP_DONE: begin
                    state_n = CAP_DONE;
                end
                default: begin
                    state_n = CAP_IDLE;
                end
            endcase
        end
    end

    // Outputs: the held pair.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_pair <= 2'b00;
        end else begin
            if (take_hi) ext_pair[1] <= ovh_bit;
            if (take_lo) ext_pair[0] <= ovh_bit;
        end
    end

    // R7: a strobe always restarts the count.
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (state == CAP_SEEK || state == CAP_TAKE_HI));

    // R7: nothing past position 7 touches the held pair.
    a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_DONE && !frame_start) |=> $stable(ext_pair));

    // R7: the idle state before the first strobe touches nothing.
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_IDLE) |=> $stable(ext_pair));

endmodule

// File: rtl/e3ma_mi_gen.sv
// Internal multiframe indicator counter, cleared on entry to automatic mode.
module e3ma_mi_gen #(
    parameter int MI_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic            auto_en,
    output logic [MI_W-1:0] mi_sel
);

    logic [MI_W-1:0] cnt;
    logic            auto_prev;

    // Value sent this frame: zero on the first automatic frame.
    always_comb begin
        mi_sel = auto_prev ? cnt : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            auto_prev <= 1'b0;
        end else if (frame_start) begin
            auto_prev <= auto_en;
            if (auto_en) begin
                cnt <= mi_sel + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end

    // R9: the counter wraps from all ones back to zero.
    a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && auto_en && auto_prev && cnt == '1) |=> (cnt == '0));

    // R10: after a non-automatic frame the next value offered is zero.
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !auto_en) |=> (mi_sel == '0));

endmodule

// File: rtl/e3ma_assemble.sv
// Builds and holds the overhead byte; loads only on the frame strobe.
module e3ma_assemble
    import e3ma_pkg::*;
#(
    parameter int MI_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic            far_fail,
    input  logic            far_err,
    input  logic [2:0]      ptype,
    input  logic [1:0]      pdep,
    input  logic            tmark,
    input  logic [(1<<MI_W)-1:0] ssm,
    input  pair_src_e       src,
    input  logic [MI_W-1:0] mi_auto,
    input  logic [1:0]      ext_pair,
    output logic [MA_W-1:0] ma_byte,
    output logic            byte_new
);

    localparam int SSM_W = 1 << MI_W;
    localparam logic [MI_W-1:0] SSM_TOP = MI_W'(SSM_W - 1);

    logic [MI_W-1:0] mi_now;
    logic [1:0]      pair;
    logic            bit8;
    logic [MA_W-1:0] next_byte;

    always_comb begin
        mi_now = (src == SRC_MI_EXT) ? MI_W'(ext_pair) : mi_auto;
        unique case (src)
            SRC_PD_REG:  pair = pdep;
            SRC_PD_EXT:  pair = ext_pair;
            SRC_MI_AUTO: pair = 2'(mi_auto);
            SRC_MI_EXT:  pair = ext_pair;
            default:     pair = pdep;
        endcase
        if (src == SRC_MI_AUTO || src == SRC_MI_EXT) begin
            bit8 = ssm[SSM_TOP - mi_now];
        end else begin
            bit8 = tmark;
        end
        next_byte = {far_fail, far_err, ptype, pair, bit8};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ma_byte  <= '0;
            byte_new <= 1'b0;
        end else begin
            byte_new <= frame_start;
            if (frame_start) begin
                ma_byte <= next_byte;
            end
        end
    end

    // R2: the byte holds between strobes.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(ma_byte));

endmodule

// File: rtl/e3ma_tx_gen.sv
module e3ma_tx_gen
    import e3ma_pkg::*;
#(
    parameter int MI_W      = 2,
    parameter int BYTE_BITS = 8,
    parameter int FIRST_POS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_start,
    input  logic        far_fail,
    input  logic        far_err,
    input  logic [2:0]  cfg_ptype,
    input  logic [1:0]  cfg_pdep,
    input  logic        cfg_tmark,
    input  logic [3:0]  cfg_ssm,
    input  logic        cfg_ssm_on,
    input  logic        cfg_ext_sel,
    input  logic        ovh_valid,
    input  logic        ovh_bit,
    output logic [7:0]  ma_byte,
    output logic        byte_new
);

    pair_src_e       src;
    logic [MI_W-1:0] mi_auto;
    logic [1:0]      ext_pair;

    always_comb begin
        src = decode_src(cfg_ssm_on, cfg_ext_sel);
    end

    e3ma_ext_capture #(
        .BYTE_BITS (BYTE_BITS),
        .FIRST_POS (FIRST_POS)
    ) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .ovh_valid   (ovh_valid),
        .ovh_bit     (ovh_bit),
        .ext_pair    (ext_pair)
    );

    e3ma_mi_gen #(
        .MI_W (MI_W)
    ) u_mi (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .auto_en     (src == SRC_MI_AUTO),
        .mi_sel      (mi_auto)
    );

    e3ma_assemble #(
        .MI_W (MI_W)
    ) u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .far_fail    (far_fail),
        .far_err     (far_err),
        .ptype       (cfg_ptype),
        .pdep        (cfg_pdep),
        .tmark       (cfg_tmark),
        .ssm         (cfg_ssm),
        .src         (src),
        .mi_auto     (mi_auto),
        .ext_pair    (ext_pair),
        .ma_byte     (ma_byte),
        .byte_new    (byte_new)
    );

    // R3: far-end flags land in the first two bits.
    a_r3_far_bits: assert property (@(posedge clk) disable iff (!rst_n)
        byte_new |-> (ma_byte[7:6] == {$past(far_fail), $past(far_err)}));

    // R4: payload type comes from the strobe-cycle value.
    a_r4_ptype: assert property (@(posedge clk) disable iff (!rst_n)
        byte_new |-> (ma_byte[5:3] == $past(cfg_ptype)));

    // R8: timing marker in bit 8 when SSM mode is off.
    a_r8_tmark: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_new && !$past(cfg_ssm_on)) |-> (ma_byte[0] == $past(cfg_tmark)));

    // R5: register payload-dependent bits.
    a_r5_pdep: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_new && !$past(cfg_ssm_on) && !$past(cfg_ext_sel))
            |-> (ma_byte[2:1] == $past(cfg_pdep)));

endmodule

// File: tb/tb_e3ma_tx_gen.sv
module tb_e3ma_tx_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       far_fail = 1'b0, far_err = 1'b0;
    logic [2:0] cfg_ptype = '0;
    logic [1:0] cfg_pdep = '0;
    logic       cfg_tmark = 1'b0;
    logic [3:0] cfg_ssm = '0;
    logic       cfg_ssm_on = 1'b0, cfg_ext_sel = 1'b0;
    logic       ovh_valid = 1'b0, ovh_bit = 1'b0;
    logic [7:0] ma_byte;
    logic       byte_new;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    e3ma_tx_gen dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .far_fail(far_fail), .far_err(far_err),
        .cfg_ptype(cfg_ptype), .cfg_pdep(cfg_pdep), .cfg_tmark(cfg_tmark),
        .cfg_ssm(cfg_ssm), .cfg_ssm_on(cfg_ssm_on), .cfg_ext_sel(cfg_ext_sel),
        .ovh_valid(ovh_valid), .ovh_bit(ovh_bit),
        .ma_byte(ma_byte), .byte_new(byte_new)
    );

    // Scoreboard queues and reference state.
    logic [7:0] exp_q[$];
    string      tag67_q[$];
    string      tag8_q[$];
    logic       m_prev_auto = 1'b0;
    logic [1:0] m_cnt = 2'b00;
    logic [1:0] m_hold = 2'b00;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: one frame of LEN cycles; ser[7] is serial position 1.
    task automatic frame(input logic [2:0] pt, input logic [1:0] pd, input logic tm,
                         input logic [3:0] ssm, input logic son, input logic xsel,
                         input logic ff, input logic fe,
                         input logic [7:0] ser, input int nbits, input int len);
        logic [1:0] pair;
        logic [1:0] mi;
        logic       b8;
        string      t67, t8;
        int         cyc;
        mi = 2'b00;
        if (!son && !xsel) begin pair = pd; t67 = "R5"; end
        else if (!son) begin pair = m_hold; t67 = "R6"; end
        else if (!xsel) begin
            mi = m_prev_auto ? m_cnt : 2'b00;
            pair = mi;
            t67 = m_prev_auto ? "R9" : "R10";
            m_cnt = mi + 2'b01;
        end else begin
            mi = m_hold; pair = mi; t67 = "R12";
        end
        b8 = son ? ssm[3 - mi] : tm;
        t8 = son ? "R11" : "R8";
        m_prev_auto = son && !xsel;
        exp_q.push_back({ff, fe, pt, pair, b8});
        tag67_q.push_back(t67);
        tag8_q.push_back(t8);
        if (nbits >= 6) m_hold[1] = ser[2];
        if (nbits >= 7) m_hold[0] = ser[1];

        @(negedge clk);
        cfg_ptype = pt; cfg_pdep = pd; cfg_tmark = tm; cfg_ssm = ssm;
        cfg_ssm_on = son; cfg_ext_sel = xsel; far_fail = ff; far_err = fe;
        frame_start = 1'b1;
        ovh_valid = (nbits > 0);
        ovh_bit = ser[7];
        cyc = 1;
        for (int i = 1; i < nbits; i++) begin
            @(negedge clk);
            frame_start = 1'b0;
            if (i == 1) begin
                // R4: mid-frame register changes must not reach the byte.
                cfg_ptype = ~pt; cfg_pdep = ~pd; cfg_tmark = ~tm; cfg_ssm = ~ssm;
                cfg_ssm_on = ~son; cfg_ext_sel = ~xsel; far_fail = ~ff; far_err = ~fe;
            end
            if (i % 2 == 1) begin
                ovh_valid = 1'b0; ovh_bit = ~ser[7 - i];
                @(negedge clk);
                cyc++;
            end
            ovh_valid = 1'b1; ovh_bit = ser[7 - i];
            cyc++;
        end
        @(negedge clk);
        frame_start = 1'b0;
        ovh_valid = 1'b0;
        cyc++;
        if (nbits >= 8) begin
            // R7: junk bits past position 7 are ignored.
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                ovh_valid = 1'b1; ovh_bit = ~ovh_bit;
                cyc++;
            end
            @(negedge clk);
            ovh_valid = 1'b0;
            cyc++;
        end
        while (cyc < len) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // Monitor.
    logic [7:0] last_byte = 8'h00;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (byte_new) begin
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R2: actual byte_new=1 expected 0 (no frame queued)");
                end else begin
                    logic [7:0] e;
                    string t67, t8;
                    e = exp_q.pop_front();
                    t67 = tag67_q.pop_front();
                    t8 = tag8_q.pop_front();
                    check("R3", {6'b0, ma_byte[7:6]}, {6'b0, e[7:6]});
                    check("R4", {5'b0, ma_byte[5:3]}, {5'b0, e[5:3]});
                    check(t67, {6'b0, ma_byte[2:1]}, {6'b0, e[2:1]});
                    check(t8, {7'b0, ma_byte[0]}, {7'b0, e[0]});
                end
                last_byte = ma_byte;
            end else begin
                check("R2", ma_byte, last_byte);
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", ma_byte, 8'h00);
        check("R1", {7'b0, byte_new}, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5 / R8: register sources, SSM off; capture pos6=1 pos7=1.
        frame(3'b101, 2'b10, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 8'b0000_0110, 7, 20);
        // R6: external pair (1,1); capture pos6=0 pos7=1 with overlong stream.
        frame(3'b010, 2'b00, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b1, 8'b0000_0010, 8, 24);
        // R6 / R7: pair (0,1); six bits only, pos6=1.
        frame(3'b111, 2'b01, 1'b1, 4'b1111, 1'b0, 1'b1, 1'b1, 1'b1, 8'b0000_0100, 6, 20);
        // R7: pair (1,1); short frame leaves it.
        frame(3'b001, 2'b01, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 8'b1111_1111, 3, 20);
        // R7: still (1,1); capture pos6=1 pos7=0.
        frame(3'b011, 2'b11, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 8'b1010_0100, 7, 20);
        // R9 / R10 / R11: automatic MI across a wrap.
        for (int k = 0; k < 6; k++) begin
            frame(3'(k), 2'b11, 1'b1, 4'b1010 ^ 4'(k), 1'b1, 1'b0, k[0], k[1], 8'h00, 0, 12);
        end
        // R12: external MI = (1,0), then capture (0,1).
        frame(3'b100, 2'b00, 1'b0, 4'b0110, 1'b1, 1'b1, 1'b0, 1'b1, 8'b0000_0010, 7, 20);
        frame(3'b110, 2'b00, 1'b1, 4'b1001, 1'b1, 1'b1, 1'b1, 1'b0, 8'b0000_0000, 0, 12);
        // R10: re-entering automatic mode restarts at 00.
        for (int k = 0; k < 3; k++) begin
            frame(3'b011, 2'b00, 1'b0, 4'b1100, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 0, 12);
        end
        // R8: SSM off again, marker toggles.
        frame(3'b000, 2'b01, 1'b0, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 0, 12);
        frame(3'b000, 2'b10, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 0, 12);

        repeat (4) @(negedge clk);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: actual %0d bytes missing expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule